// File: doc/BRIEF.md
# DMA Source Read Burst Sequencer

This block produces the stream of read requests for the source side of one DMA channel. Software-visible storage holds a start address and a configuration word. The configuration word picks the beat count of a programmed burst, whether the address increments or stays fixed, and the access size. A start pulse with a total beat count launches an operation. The block copies the address and configuration into working state, then emits one request at a time on a simple valid/ready master request port. Each request carries an address, an effective access size and a beat count.

Before each request the sequencer checks two alignments. The address must be a multiple of the access size. For a multi-beat burst it must also be a multiple of the access size times the beat count. When the address fails a check, the sequencer issues single-beat accesses, at a reduced width if needed, until the address lines up again. Once enough beats remain, it returns to the programmed burst. The last beats of an operation come out as singles. A constant-address operation reads one location over and over with single beats. A one-cycle done pulse follows acceptance of the final request.

Top module: `src_burst_seq`

## Requirements
- R1: The source address register is 32 bits wide, resets to 0 and can be written and read back. `reg_sel` = 0 selects it. `reg_rdata` shows the selected register one clock after `reg_sel` is applied.
- R2: The configuration register (`reg_sel` = 1) holds burst code bits 18:16, the constant-address flag bit 8 and the size code bits 1:0. All other bits read 0 and ignore writes. After reset it reads 0x0004_0002.
- R3: Burst code 000 gives 1 beat, 010 gives 4, 011 gives 8 and 100 gives 16. Codes 001, 101, 110 and 111 give single-beat requests only.
- R4: Size code 00 is byte (1 byte), 01 is halfword (2 bytes) and 10 is word (4 bytes). Code 11 behaves as word, and requests then report `req_size` = 10.
- R5: A multi-beat request (`req_len` > 1) is issued only under three conditions: the address is a multiple of size-bytes × beats, the address is size-aligned, and at least that many beats remain. Otherwise the request is a single beat. In incrementing mode the next address is the previous one plus `req_len` × size-bytes.
- R6: When the address is not a multiple of the configured size, the request is a single beat. Its size is halfword if the address is even and byte if it is odd. The address then advances by that reduced width.
- R7: With the constant-address flag set, every request is a single beat to the start address.
- R8: A start pulse while idle latches the address and configuration registers and the beat count. Register writes and start pulses made while an operation runs do not affect it. A request holds its address, size and length until `req_ready` is high.
- R9: `done` pulses for one cycle in the clock after the final request is accepted. A start with a count of 0 produces no request and pulses `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address, 1 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| start | input | 1 | Begin an operation (ignored while busy) |
| total_beats | input | 16 | Number of beats to read, sampled with start |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_addr | output | 32 | Request byte address |
| req_size | output | 2 | Effective access size code |
| req_len | output | 5 | Beats in this request: 1, 4, 8 or 16 |
| done | output | 1 | One-cycle pulse after the final request is accepted |

## Verification
The assertions assume three things about the inputs. `req_ready` may be held low for any number of cycles but is never undefined. `total_beats` is only sampled with `start`. Reset is applied before the first request. The hold check relies on the requester never withdrawing a request on its own. The stimulus drives inputs one time step after a rising edge and samples outputs on falling edges. It alternates between an always-ready sink and a sink that stalls one cycle in three, so requests are held across stalls. The alignment and constant-mode checks then see requests produced under every config pattern the bench applies.

// File: rtl/src_seq_pkg.sv
package src_seq_pkg;

  localparam int BURST_LSB = 16;
  localparam int MODE_BIT  = 8;
  localparam int SIZE_LSB  = 0;
  localparam int LEN_W     = 5;
  localparam int SPAN_W    = 7;

  typedef struct packed {
    logic [2:0] burst;
    logic       const_mode;
    logic [1:0] size;
  } src_cfg_t;

  localparam src_cfg_t CFG_RESET = '{burst: 3'b100, const_mode: 1'b0, size: 2'b10};

  function automatic logic [LEN_W-1:0] burst_beats(input logic [2:0] code);
    case (code)
      3'b010:  burst_beats = 5'd4;
      3'b011:  burst_beats = 5'd8;
      3'b100:  burst_beats = 5'd16;
      default: burst_beats = 5'd1;
    endcase
  endfunction

  function automatic logic [1:0] norm_size(input logic [1:0] code);
    norm_size = (code == 2'b11) ? 2'b10 : code;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] ncode);
    case (ncode)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
  import src_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] start_addr,
  output src_cfg_t          cfg,
  output logic [ADDR_W-1:0] rdata
);

  logic [ADDR_W-1:0] cfg_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      cfg        <= CFG_RESET;
    end else if (we) begin
      if (!sel) begin
        start_addr <= wdata;
      end else begin
        cfg.burst      <= wdata[BURST_LSB +: 3];
        cfg.const_mode <= wdata[MODE_BIT];
        cfg.size       <= wdata[SIZE_LSB +: 2];
      end
    end
  end

  always_comb begin
    cfg_word                  = '0;
    cfg_word[BURST_LSB +: 3]  = cfg.burst;
    cfg_word[MODE_BIT]        = cfg.const_mode;
    cfg_word[SIZE_LSB +: 2]   = cfg.size;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel ? cfg_word : start_addr;
  end

  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    we && !sel |=> start_addr == $past(wdata)); // R1

endmodule

// File: rtl/seq_plan.sv
module seq_plan
  import src_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [SPAN_W-1:0] addr_lo,
  input  logic [CNT_W-1:0]  rem,
  input  src_cfg_t          cfg,
  output logic [LEN_W-1:0]  len,
  output logic [1:0]        size,
  output logic [SPAN_W-1:0] adv
);

  logic [1:0]        ncode;
  logic [2:0]        nbytes;
  logic [LEN_W-1:0]  beats;
  logic [SPAN_W-1:0] span;
  logic              size_ok;
  logic              span_ok;
  logic              rem_ok;
  logic              use_burst;
  logic [1:0]        fb_code;

  always_comb begin
    ncode  = norm_size(cfg.size);
    nbytes = size_bytes(ncode);
    beats  = burst_beats(cfg.burst);
    span   = SPAN_W'(nbytes) * SPAN_W'(beats);
    case (ncode)
      2'b00:   size_ok = 1'b1;
      2'b01:   size_ok = !addr_lo[0];
      default: size_ok = (addr_lo[1:0] == 2'b00);
    endcase
    fb_code   = addr_lo[0] ? 2'b00 : 2'b01;
    span_ok   = ((addr_lo & (span - SPAN_W'(1))) == '0);
    rem_ok    = (rem >= CNT_W'(beats));
    use_burst = (beats != LEN_W'(1)) && !cfg.const_mode && size_ok && span_ok && rem_ok;
    len       = use_burst ? beats : LEN_W'(1);
    size      = size_ok ? ncode : fb_code;
    adv       = use_burst ? span : SPAN_W'(size_bytes(size));
  end

endmodule

// File: rtl/seq_issue.sv
module seq_issue
  import src_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_beats,
  input  logic [ADDR_W-1:0] start_addr,
  input  src_cfg_t          cfg,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [LEN_W-1:0]  req_len,
  output logic              done
);

  logic              run;
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] cur_addr;
  src_cfg_t          cfg_q;
  logic [LEN_W-1:0]  nxt_len;
  logic [1:0]        nxt_size;
  logic [SPAN_W-1:0] nxt_adv;
  logic              load;
  logic              accept;

  seq_plan #(.CNT_W(CNT_W)) u_plan (
    .addr_lo (cur_addr[SPAN_W-1:0]),
    .rem     (rem),
    .cfg     (cfg_q),
    .len     (nxt_len),
    .size    (nxt_size),
    .adv     (nxt_adv)
  );

  assign accept = req_valid && req_ready;
  assign load   = run && (rem != '0) && (!req_valid || req_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      rem       <= '0;
      cur_addr  <= '0;
      cfg_q     <= CFG_RESET;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_len   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          if (total_beats == '0) begin
            done <= 1'b1;
          end else begin
            run      <= 1'b1;
            rem      <= total_beats;
            cur_addr <= start_addr;
            cfg_q    <= cfg;
          end
        end
      end else if (load) begin
        req_valid <= 1'b1;
        req_addr  <= cur_addr;
        req_size  <= nxt_size;
        req_len   <= nxt_len;
        rem       <= rem - CNT_W'(nxt_len);
        if (!cfg_q.const_mode) cur_addr <= cur_addr + ADDR_W'(nxt_adv);
      end else if (accept) begin
        req_valid <= 1'b0;
        run       <= 1'b0;
        done      <= 1'b1;
      end
    end
  end

  logic [SPAN_W-1:0] chk_span;
  assign chk_span = SPAN_W'(size_bytes(req_size)) * SPAN_W'(req_len);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_size)); // R8
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_len != LEN_W'(1) |-> (req_addr[SPAN_W-1:0] & (chk_span - SPAN_W'(1))) == '0); // R5
  AST_SIZE_NATURAL: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_size == 2'b00) || (req_size == 2'b01 && !req_addr[0]) ||
                  (req_size == 2'b10 && req_addr[1:0] == 2'b00)); // R6
  AST_CONST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && cfg_q.const_mode |-> req_len == LEN_W'(1)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid); // R9

endmodule

// File: rtl/src_burst_seq.sv
module src_burst_seq
  import src_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_beats,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [LEN_W-1:0]  req_len,
  output logic              done
);

  logic [ADDR_W-1:0] start_addr;
  src_cfg_t          cfg;

  seq_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .start_addr (start_addr),
    .cfg        (cfg),
    .rdata      (reg_rdata)
  );

  seq_issue #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_issue (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .total_beats (total_beats),
    .start_addr  (start_addr),
    .cfg         (cfg),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_len     (req_len),
    .done        (done)
  );

endmodule

// File: tb/sim_src_burst_seq.sv
module sim_src_burst_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        start = 1'b0;
  logic [15:0] total_beats = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [4:0]  req_len;
  logic        done;

  always #4 clk = ~clk;

  src_burst_seq u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start(start), .total_beats(total_beats),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_len(req_len), .done(done)
  );

  typedef struct { logic [31:0] a; logic [4:0] n; logic [1:0] s; } item_t;
  item_t exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    done_seen = 0;
  bit    expect_done = 0;
  int    stall_mode = 0;
  string cur_tag = "R1";

  task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      req_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (expect_done) begin
        report({cur_tag, " R9 done after final accept"}, {63'b0, done}, 64'd1);
        expect_done = 0;
      end
      if (done) done_seen++;
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL %s R8 unexpected request actual=%h expected=none", cur_tag, req_addr);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          report({cur_tag, " request addr/len/size"}, {25'b0, req_addr, req_len, req_size},
                 {25'b0, it.a, it.n, it.s});
          if (exp_q.size() == 0) expect_done = 1;
        end
      end
    end
  end

  task automatic push_model(input logic [31:0] a0, input logic [31:0] cfg, input int cnt);
    int s, l, rem, adv, n;
    logic [1:0]  sc, ec;
    logic [31:0] a;
    bit cm;
    s  = (cfg[1:0] == 2'd0) ? 1 : (cfg[1:0] == 2'd1) ? 2 : 4;
    sc = (cfg[1:0] == 2'd3) ? 2'd2 : cfg[1:0];
    case (cfg[18:16])
      3'd2: l = 4;
      3'd3: l = 8;
      3'd4: l = 16;
      default: l = 1;
    endcase
    cm = cfg[8];
    a = a0;
    rem = cnt;
    while (rem > 0) begin
      if ((a % s) != 0) begin
        n = 1; adv = (a % 2 != 0) ? 1 : 2; ec = (a % 2 != 0) ? 2'd0 : 2'd1;
      end else if (l > 1 && !cm && rem >= l && (a % (s * l)) == 0) begin
        n = l; adv = s * l; ec = sc;
      end else begin
        n = 1; adv = s; ec = sc;
      end
      exp_q.push_back('{a: a, n: 5'(n), s: ec});
      if (!cm) a = a + 32'(adv);
      rem = rem - n;
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic sel, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_sel = sel;
    @(posedge clk);
    @(negedge clk);
    report(tag, {32'b0, reg_rdata}, {32'b0, exp});
  endtask

  task automatic pulse_start(input int cnt);
    @(posedge clk); #1;
    start = 1'b1; total_beats = 16'(cnt);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int guard = 0;
    while (done_seen <= d0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 3000) begin
      n_chk++; n_bad++;
      $display("FAIL %s R9 done not seen actual=timeout expected=done", cur_tag);
    end
    repeat (3) @(negedge clk);
    report({cur_tag, " queue drained"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] cfg,
                        input int cnt, input int stall);
    int d0;
    cur_tag = tag;
    stall_mode = stall;
    wr(1'b0, a);
    wr(1'b1, cfg);
    push_model(a, cfg, cnt);
    d0 = done_seen;
    pulse_start(cnt);
    wait_done(d0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    report("R9 reset req_valid", {63'b0, req_valid}, 64'd0);
    report("R9 reset done", {63'b0, done}, 64'd0);
    rd_check(1'b0, 32'h0, "R1 reset address");
    rd_check(1'b1, 32'h0004_0002, "R2 reset config");

    wr(1'b1, 32'hFFFF_FFFF);
    rd_check(1'b1, 32'h0007_0103, "R2 reserved bits read zero");
    wr(1'b0, 32'hA5C3_1234);
    rd_check(1'b0, 32'hA5C3_1234, "R1 address readback");

    run_op("R5 aligned word x16", 32'h0000_1000, 32'h0004_0002, 32, 0);
    run_op("R5 misaligned to span word x4", 32'h0000_1008, 32'h0002_0002, 10, 1);
    run_op("R6 misaligned to size", 32'h0000_2001, 32'h0002_0002, 6, 0);
    run_op("R7 constant address", 32'h0000_3000, 32'h0003_0102, 5, 1);
    run_op("R3 reserved burst code", 32'h0000_4000, 32'h0001_0001, 4, 0);
    run_op("R3 single burst code", 32'h0000_4100, 32'h0000_0002, 3, 0);
    run_op("R4 size 11 as word x8 tail", 32'h0000_0040, 32'h0003_0003, 11, 1);
    run_op("R4 byte x16", 32'h0000_0010, 32'h0004_0000, 20, 0);
    run_op("R4 halfword x8", 32'h0000_0030, 32'h0003_0001, 20, 1);

    begin
      int d0;
      cur_tag = "R9 zero count";
      d0 = done_seen;
      @(posedge clk); #1;
      start = 1'b1; total_beats = 16'd0;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      report("R9 zero count done pulse", {63'b0, done}, 64'd1);
      repeat (5) @(negedge clk);
      report("R9 zero count single done", 64'(done_seen - d0), 64'd1);
    end

    begin
      int d0;
      cur_tag = "R8 busy";
      stall_mode = 1;
      wr(1'b0, 32'h0000_5000);
      wr(1'b1, 32'h0002_0002);
      push_model(32'h0000_5000, 32'h0002_0002, 16);
      d0 = done_seen;
      pulse_start(16);
      wr(1'b0, 32'hDEAD_0000);
      wr(1'b1, 32'h0000_0100);
      pulse_start(7);
      wait_done(d0);
      repeat (10) @(negedge clk);
      report("R8 one done for busy start", 64'(done_seen - d0), 64'd1);
      rd_check(1'b0, 32'hDEAD_0000, "R1 address written while busy");
    end

    finish_run();
  end

endmodule